// File: doc/BRIEF.md
# Block Queue with Random-Access Containers

This block couples a producer process to a consumer process through a queue whose unit of transfer is a whole container of words, not a single word. Each side works on one active container at a time. Within that container it may read or write any word, in any order, through its own address, write-data and read-data ports. It picks the action with a two-bit operation code. A commit hands the container over: the producer's commit appends its finished container to the queue, and the consumer's commit frees the container at the head.

The producer sees a full flag and the consumer sees an empty flag, so both sides can stall until the other catches up. Because access inside a container is random, words can be produced in one order (for example a zigzag scan) and consumed in another. A producer may also commit after writing only part of a container, and either side may keep scratch values in its active container. The number of containers and the words per container are parameters. Containers are recycled in ring order.

Top module: `blk_queue`

## Requirements
- R1: After reset the consumer empty flag is 1, the producer full flag is 0, and both sides' active containers are container 0 of the ring.
- R2: Each side's operation code is 2 bits: 00 idle, 01 read, 10 write, 11 commit. An idle cycle changes no flag, no stored word and no read-data output.
- R3: A read returns the word at the given address of that side's active container on the read-data port one clock after the read op. The port holds that value until the next read on the same side. Addresses may be visited in any order.
- R4: A producer commit while not full appends the producer's active container to the queue. Empty is 0 in the following cycle, and full becomes 1 once the queue holds all containers.
- R5: A consumer commit while not empty frees the head container. Containers reach the consumer in the order they were committed.
- R6: A producer commit or a producer write while full is ignored: the flags and the queued data stay unchanged.
- R7: A consumer commit while empty is ignored: empty stays 1, and the next producer commit makes exactly one container available.
- R8: When both sides commit in the same cycle, the container count changes by the net of the accepted commits: unchanged when both are accepted, +1 when empty, and -1 when full.
- R9: A producer may commit a partly written container. Words it did not write keep whatever that ring slot held from its previous use. Slots are reused in the order 0, 1, ..., n-1, 0, ...
- R10: Either side may write into its own active container and read the value back before committing. A consumer write is ignored while empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p_op | input | 2 | Producer operation code |
| p_addr | input | $clog2(WORDS) | Producer word address in its active container |
| p_wdata | input | DW | Producer write data |
| p_rdata | output | DW | Producer read data, one cycle after a read |
| p_full | output | 1 | Queue holds NBLK containers |
| c_op | input | 2 | Consumer operation code |
| c_addr | input | $clog2(WORDS) | Consumer word address in its active container |
| c_wdata | input | DW | Consumer scratch write data |
| c_rdata | output | DW | Consumer read data, one cycle after a read |
| c_empty | output | 1 | Queue holds no containers |

## Verification
The hardest cases to reach are the ones at the two count limits. One is a same-cycle commit from both sides while the queue is empty or full, where only one of the two commits may count. The other is a producer write while full, which aims at the very container the consumer is reading. The stimulus sweeps the starting count over every value from zero to the depth, fires both commits together, and then drains while counting how many consumer commits it takes to reach empty. A junk write and a commit are issued at full, and the head container is then read back in full. Stale words in a partly written container are predicted from a bench-side model of every ring slot.

// File: rtl/blk_queue.sv
`timescale 1ns/1ps
module blk_queue #(
  parameter int NBLK  = 4,
  parameter int WORDS = 8,
  parameter int DW    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               p_op,
  input  logic [$clog2(WORDS)-1:0] p_addr,
  input  logic [DW-1:0]            p_wdata,
  output logic [DW-1:0]            p_rdata,
  output logic                     p_full,
  input  logic [1:0]               c_op,
  input  logic [$clog2(WORDS)-1:0] c_addr,
  input  logic [DW-1:0]            c_wdata,
  output logic [DW-1:0]            c_rdata,
  output logic                     c_empty
);
  localparam int PW = $clog2(NBLK);
  localparam int CW = $clog2(NBLK + 1);
  localparam int MW = $clog2(NBLK * WORDS);
  localparam logic [1:0] OP_RD = 2'b01, OP_WR = 2'b10, OP_CM = 2'b11;

  logic [DW-1:0] mem [NBLK*WORDS];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic [MW-1:0] p_idx, c_idx;
  logic          p_cm, c_cm;

  assign p_full  = (cnt == CW'(NBLK));
  assign c_empty = (cnt == '0);
  assign p_cm    = (p_op == OP_CM) && !p_full;
  assign c_cm    = (c_op == OP_CM) && !c_empty;
  assign p_idx   = MW'(wr_ptr * WORDS + p_addr);
  assign c_idx   = MW'(rd_ptr * WORDS + c_addr);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(NBLK - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (p_op == OP_WR && !p_full)  mem[p_idx] <= p_wdata;
    if (c_op == OP_WR && !c_empty) mem[c_idx] <= c_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      p_rdata <= '0;
      c_rdata <= '0;
    end else begin
      if (p_cm) wr_ptr <= nxt(wr_ptr);
      if (c_cm) rd_ptr <= nxt(rd_ptr);
      case ({p_cm, c_cm})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (p_op == OP_RD) p_rdata <= mem[p_idx];
      if (c_op == OP_RD) c_rdata <= mem[c_idx];
    end
  end

  a_r3_p_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (p_op != OP_RD) |=> $stable(p_rdata));
  a_r3_c_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (c_op != OP_RD) |=> $stable(c_rdata));
  a_r4_commit_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (p_op == OP_CM && !p_full && c_op != OP_CM) |=> !c_empty);
  a_r6_full_commit_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (p_op == OP_CM && p_full && c_op != OP_CM) |=> p_full);
  a_r7_empty_commit_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (c_op == OP_CM && c_empty && p_op != OP_CM) |=> c_empty);
  a_r8_dual_commit_net: assert property (@(posedge clk) disable iff (!rst_n)
    (p_op == OP_CM && c_op == OP_CM && !p_full && !c_empty)
      |=> ($stable(p_full) && $stable(c_empty)));
  a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (p_op == 2'b00 && c_op == 2'b00) |=> ($stable(p_full) && $stable(c_empty)));
endmodule

// File: tb/blk_queue_tb_top.sv
`timescale 1ns/1ps
module blk_queue_tb_top;
  localparam int N = 4, W = 8, DW = 16;
  localparam logic [1:0] NOP = 2'b00, RD = 2'b01, WR = 2'b10, CM = 2'b11;

  logic clk = 0, rst_n = 0;
  logic [1:0] p_op = NOP, c_op = NOP;
  logic [2:0] p_addr = '0, c_addr = '0;
  logic [DW-1:0] p_wdata = '0, c_wdata = '0, p_rdata, c_rdata;
  logic p_full, c_empty;

  int total = 0, bad = 0, cnt = 0, wp = 0, rp = 0;
  bit done = 0;
  logic [DW-1:0] em [N][W];

  always #2.5 clk = ~clk;

  blk_queue #(.NBLK(N), .WORDS(W), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .p_op(p_op), .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata), .p_full(p_full),
    .c_op(c_op), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata), .c_empty(c_empty));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(logic [1:0] po, int pa, logic [DW-1:0] pd,
                     logic [1:0] co, int ca, logic [DW-1:0] cd);
    p_op = po; p_addr = 3'(pa); p_wdata = pd;
    c_op = co; c_addr = 3'(ca); c_wdata = cd;
    @(posedge clk);
    @(negedge clk);
    p_op = NOP; c_op = NOP;
  endtask

  task automatic flags(string req);
    chk({req, " empty"}, 32'(c_empty), 32'(cnt == 0));
    chk({req, " full"},  32'(p_full),  32'(cnt == N));
  endtask

  function automatic logic [DW-1:0] pat(int s, int a);
    return DW'(s * 97 + a * 13 + 5);
  endfunction

  task automatic pwrite(int a, logic [DW-1:0] d);
    cyc(WR, a, d, NOP, 0, 0);
    if (cnt < N) em[wp][a] = d;
  endtask
  task automatic cwrite(int a, logic [DW-1:0] d);
    cyc(NOP, 0, 0, WR, a, d);
    if (cnt > 0) em[rp][a] = d;
  endtask
  task automatic pread(string req, int a);
    cyc(RD, a, 0, NOP, 0, 0);
    chk(req, 32'(p_rdata), 32'(em[wp][a]));
  endtask
  task automatic cread(string req, int a);
    cyc(NOP, 0, 0, RD, a, 0);
    chk(req, 32'(c_rdata), 32'(em[rp][a]));
  endtask
  task automatic pcommit();
    cyc(CM, 0, 0, NOP, 0, 0);
    if (cnt < N) begin cnt++; wp = (wp + 1) % N; end
  endtask
  task automatic ccommit();
    cyc(NOP, 0, 0, CM, 0, 0);
    if (cnt > 0) begin cnt--; rp = (rp + 1) % N; end
  endtask
  task automatic fill_one(int seed);
    for (int i = 0; i < W; i++) pwrite((i * 3) % W, pat(seed, (i * 3) % W));
    pcommit();
  endtask
  task automatic drain_one(string req);
    for (int i = 0; i < W; i++) cread(req, (i * 5 + 2) % W);
    ccommit();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    flags("R1 reset");

    // R4 / R10: fill every container in a permuted (zigzag-like) order, read back as scratch
    for (int b = 0; b < N; b++) begin
      for (int i = 0; i < W; i++) pwrite((i * 3) % W, pat(b, (i * 3) % W));
      pread("R10 producer scratch readback", (b * 5) % W);
      pcommit();
      flags("R4 after producer commit");
    end

    // R6: write and commit while full are ignored
    pwrite(0, 16'hDEAD);
    pcommit();
    flags("R6 commit while full");

    // R3 / R5 / R1: head container is the first one written, read in another order
    for (int i = 0; i < W; i++) cread("R3 R1 head container", (i * 5) % W);
    // R3: read data holds across idle cycles (R2)
    cyc(NOP, 0, 16'h1234, NOP, 0, 16'h5678);
    chk("R2 R3 idle keeps read data", 32'(c_rdata), 32'(em[rp][3]));
    flags("R2 idle keeps flags");

    // R10: consumer scratch write and readback
    cwrite(2, 16'hBEEF);
    cread("R10 consumer scratch", 2);

    // R5: drain in order
    for (int b = 0; b < N; b++) begin
      ccommit();
      flags("R5 after consumer commit");
      if (cnt > 0) for (int i = 0; i < W; i++) cread("R5 FIFO order", W - 1 - i);
    end

    // R7: consumer commit and write while empty are ignored
    ccommit();
    flags("R7 commit while empty");
    cwrite(1, 16'h0BAD);
    fill_one(40);
    flags("R7 one available");
    drain_one("R7 R10 data after empty ops");
    flags("R7 drained to empty");

    // R8: sweep starting count 0..N with simultaneous commits
    for (int s = 0; s <= N; s++) begin
      for (int b = 0; b < s; b++) fill_one(100 + s * 10 + b);
      for (int i = 0; i < W; i++) pwrite(i, pat(200 + s, i));
      begin
        bit pc, cc;
        pc = (cnt < N); cc = (cnt > 0);
        cyc(CM, 0, 0, CM, 0, 0);
        if (cc) begin cnt--; rp = (rp + 1) % N; end
        if (pc) begin cnt++; wp = (wp + 1) % N; end
      end
      flags("R8 dual commit");
      begin
        int n_exp, n_got;
        n_exp = cnt; n_got = 0;
        while (!c_empty && n_got < N + 1) begin
          drain_one("R8 data after dual commit");
          n_got++;
        end
        chk("R8 containers after dual commit", 32'(n_got), 32'(n_exp));
      end
    end

    // R9: partial container keeps stale words from the slot's previous use
    pwrite(0, 16'h00A5);
    pcommit();
    flags("R9 partial commit");
    cread("R9 written word", 0);
    cread("R9 stale word", 5);
    cread("R9 stale word", 7);
    ccommit();
    flags("R9 drained");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule